// File: doc/BRIEF.md
# Serial Nibble Transmitter with Shared Port Pins

This block is a small serial transmitter inside a 4-bit microcontroller. Software writes a 4-bit data nibble, and the block sends it as a serial data line with a generated serial clock. While it is active, the block takes over the two low pins of a 4-bit general-purpose port. The rate of the serial clock comes from one of four prescaler taps. Each tap arrives as a single-cycle enable pulse on the system clock, and each pulse toggles the serial clock once.

A 4-bit control word holds an enable bit and a clock-rate selector. The block drives one status line into the processor's branch-condition input. While the block is disabled, that line carries the port A bit 2 input. While it is enabled, the line carries the block's own status. In automatic mode the status means "transmission finished". In interactive mode it means "buffer empty", and software can queue the next nibble while the current one is still being sent.

Top module: `serial_nibble_tx`

## Requirements
- R1: After reset the control word reads 0. A control write stores bit 3 (enable) and bits 1:0 (rate selector). Bit 2 always reads 0.
- R2: `port_dir_out` = 0 makes all four pin enables 0 and passes `port_out` to `pins_out`. With `port_dir_out` = 1 and enable = 0, all four pins are enabled and carry `port_out`. With both set, pin 0 carries the serial clock, pin 1 carries the serial data, and pins 3:2 carry `port_out[3:2]`.
- R3: Selector value k (0..3) makes only `tap_tick[k]` advance the serial clock. These are the taps for about 1, 2, 8 and 16 kHz. Pulses on the other taps have no effect.
- R4: A nibble is sent LSB first. Each bit takes two tick pulses: the first raises the serial clock and sets the data bit in the same cycle, and the second lowers the clock.
- R5: While idle, the serial clock rests low and the data line keeps the last bit sent (0 after reset).
- R6: With enable = 0, `cond_flag` equals `pa2_in`. With enable = 1, it carries the transmitter status.
- R7: In interactive mode (`auto_mode` = 0), the status is 1 when the holding buffer is empty. A data write clears it in the next cycle. It sets again one cycle later, when the nibble moves into the shifter, and a queued nibble is sent after the current one.
- R8: In automatic mode (`auto_mode` = 1), the status resets to 0. It sets on the same edge that lowers the clock of the last bit, provided nothing is queued, and a data write clears it.
- R9: A selector change made in the middle of a bit takes effect only after that bit's falling clock edge.
- R10: While enable = 0, data writes are ignored and the serial clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word write data |
| ctrl_rdata | output | 4 | Control word read value |
| data_we | input | 1 | Data nibble write strobe |
| data_wdata | input | 4 | Data nibble to send |
| auto_mode | input | 1 | 1 = automatic send mode, 0 = interactive |
| tap_tick | input | 4 | Prescaler tap enable pulses, index = selector |
| port_dir_out | input | 1 | Port output-mode bit |
| port_out | input | 4 | Ordinary port output values |
| pins_out | output | 4 | Pin output values |
| pins_oe | output | 4 | Pin output enables |
| pa2_in | input | 1 | Port A bit 2 input |
| cond_flag | output | 1 | Branch-condition status line |

## Verification
The hardest case to reach is a selector change that lands inside a bit period. The bench writes a new selector while the serial clock is high. It then pulses the old tap to prove that this tap still ends the bit. Next it pulses the old tap again to prove that it no longer starts the next bit, and then pulses the new tap. Queuing in interactive mode is also hard to reach: the bench writes a second nibble while the first is still shifting, then watches the buffer-empty flag rise again once the hand-over happens.

// File: rtl/serial_nibble_tx.sv
module serial_nibble_tx #(
  parameter int DATA_W = 4,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [3:0] ctrl_wdata,
  output logic [3:0] ctrl_rdata,
  input  logic       data_we,
  input  logic [3:0] data_wdata,
  input  logic       auto_mode,
  input  logic [3:0] tap_tick,
  input  logic       port_dir_out,
  input  logic [3:0] port_out,
  output logic [3:0] pins_out,
  output logic [3:0] pins_oe,
  input  logic       pa2_in,
  output logic       cond_flag
);

  logic              en;
  logic [1:0]        sel, sel_act;
  logic [DATA_W-1:0] hold, shreg;
  logic              hold_full, busy, sclk, sdata, fin;
  logic [CNT_W-1:0]  cnt;

  wire tick      = tap_tick[sel_act];
  wire load      = en && hold_full && !busy;
  wire last_fall = busy && tick && sclk && (cnt == '0);
  wire wr_ok     = data_we && en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en  <= 1'b0;
      sel <= 2'b00;
    end else if (ctrl_we) begin
      en  <= ctrl_wdata[3];
      sel <= ctrl_wdata[1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (!en) begin
      hold_full <= 1'b0;
    end else if (wr_ok) begin
      hold      <= data_wdata[DATA_W-1:0];
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      sdata   <= 1'b0;
      shreg   <= '0;
      cnt     <= '0;
      sel_act <= 2'b00;
    end else if (!en) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      sel_act <= sel;
    end else if (load) begin
      busy    <= 1'b1;
      shreg   <= hold;
      cnt     <= CNT_W'(DATA_W);
      sel_act <= sel;
    end else if (!busy) begin
      sel_act <= sel;
    end else if (tick) begin
      if (!sclk) begin
        sclk  <= 1'b1;
        sdata <= shreg[0];
        shreg <= shreg >> 1;
        cnt   <= cnt - 1'b1;
      end else begin
        sclk    <= 1'b0;
        sel_act <= sel;
        if (cnt == '0) busy <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      fin <= 1'b0;
    else if (wr_ok)                  fin <= 1'b0;
    else if (last_fall && !hold_full) fin <= 1'b1;

  wire take_pins = port_dir_out && en;
  wire status    = auto_mode ? fin : !hold_full;

  assign ctrl_rdata = {en, 1'b0, sel};
  assign pins_oe    = {4{port_dir_out}};
  assign pins_out   = take_pins ? {port_out[3:2], sdata, sclk} : port_out;
  assign cond_flag  = en ? status : pa2_in;

endmodule

module serial_nibble_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ctrl_rdata,
  input logic       cond_flag,
  input logic       pa2_in,
  input logic       en,
  input logic       busy,
  input logic       sclk,
  input logic       sdata,
  input logic [1:0] sel_act
);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[2] == 1'b0);

  a_r6_cond_from_port: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> cond_flag == pa2_in);

  a_r4_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $rose(sclk));

  a_r5_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r9_sel_held_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sel_act));

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> !sclk);

endmodule

bind serial_nibble_tx serial_nibble_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_rdata(ctrl_rdata), .cond_flag(cond_flag),
  .pa2_in(pa2_in), .en(en), .busy(busy), .sclk(sclk), .sdata(sdata),
  .sel_act(sel_act)
);

// File: tb/test_serial_nibble_tx.sv
module test_serial_nibble_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 0, data_we = 0, auto_mode = 1, port_dir_out = 0, pa2_in = 0;
  logic [3:0] ctrl_wdata = 0, data_wdata = 0, tap_tick = 0, port_out = 0;
  logic [3:0] ctrl_rdata, pins_out, pins_oe;
  logic cond_flag;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_nibble_tx i_serial_nibble_tx (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .data_we(data_we), .data_wdata(data_wdata),
    .auto_mode(auto_mode), .tap_tick(tap_tick), .port_dir_out(port_dir_out),
    .port_out(port_out), .pins_out(pins_out), .pins_oe(pins_oe),
    .pa2_in(pa2_in), .cond_flag(cond_flag)
  );

  // {pm, ctrl[3:0], port_out[3:0], pa2} -> {rdata[3:0], oe[3:0], pins[3:0], cond}
  localparam logic [22:0] VEC [6] = '{
    {1'b0, 4'b0000, 4'hA, 1'b1, 4'h0, 4'h0, 4'hA, 1'b1},
    {1'b0, 4'b1000, 4'h5, 1'b1, 4'h8, 4'h0, 4'h5, 1'b0},
    {1'b1, 4'b0111, 4'hF, 1'b1, 4'h3, 4'hF, 4'hF, 1'b1},
    {1'b1, 4'b1101, 4'hF, 1'b1, 4'h9, 4'hF, 4'hC, 1'b0},
    {1'b1, 4'b0010, 4'h6, 1'b0, 4'h2, 4'hF, 4'h6, 1'b0},
    {1'b1, 4'b1110, 4'h3, 1'b1, 4'hA, 4'hF, 4'h0, 1'b0}
  };

  task automatic check(string req, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [3:0] v);
    ctrl_wdata = v; ctrl_we = 1; cyc(); ctrl_we = 0;
  endtask

  task automatic wr_data(logic [3:0] v);
    data_wdata = v; data_we = 1; cyc(); data_we = 0;
  endtask

  task automatic pulse(int k);
    tap_tick = 4'(1 << k); cyc(); tap_tick = 0;
  endtask

  initial begin
    cyc(400000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(2);
    check("R1 reset", 13'(ctrl_rdata), 13'h0);
    check("R8 reset fin", 13'(cond_flag), 13'(pa2_in));
    rst_n = 1; cyc(2);

    foreach (VEC[i]) begin
      port_dir_out = VEC[i][22]; port_out = VEC[i][17:14]; pa2_in = VEC[i][13];
      wr_ctrl(VEC[i][21:18]);
      check($sformatf("R1 R2 R6 vec%0d", i), {ctrl_rdata, pins_oe, pins_out, cond_flag},
            VEC[i][12:0]);
    end

    // R4/R8: automatic send, selector 2, nibble 1011
    auto_mode = 1; port_dir_out = 1; port_out = 0; pa2_in = 1;
    wr_ctrl(4'b1010);
    wr_data(4'b1011);
    check("R8 clear on write", 13'(cond_flag), 13'h0);
    cyc();
    for (int b = 0; b < 4; b++) begin
      pulse(2);
      check($sformatf("R4 rise bit%0d", b), 13'(pins_out[1:0]), 13'({4'b1011 >> b & 1'b1, 1'b1}));
      if (b == 1) begin
        pulse(0);
        check("R3 other tap ignored", 13'(pins_out[0]), 13'h1);
      end
      if (b == 3) check("R8 not before last fall", 13'(cond_flag), 13'h0);
      pulse(2);
      check($sformatf("R4 fall bit%0d", b), 13'(pins_out[0]), 13'h0);
    end
    check("R8 finished", 13'(cond_flag), 13'h1);
    pulse(2); pulse(2);
    check("R5 idle hold", 13'(pins_out[1:0]), 13'b10);

    // R9: selector change mid-bit, nibble 0101
    wr_data(4'b0101); cyc();
    pulse(2);
    check("R9 first rise", 13'(pins_out[1:0]), 13'b11);
    wr_ctrl(4'b1000);
    pulse(2);
    check("R9 old tap ends bit", 13'(pins_out[0]), 13'h0);
    pulse(2);
    check("R9 old tap no longer starts", 13'(pins_out[0]), 13'h0);
    pulse(0);
    check("R9 R3 new tap starts bit", 13'(pins_out[1:0]), 13'b01);
    for (int b = 0; b < 5; b++) pulse(0);
    for (int b = 0; b < 2; b++) pulse(0);
    check("R8 second finish", 13'(cond_flag), 13'h1);

    // R7: interactive queueing, selector 0
    auto_mode = 0;
    check("R7 empty idle", 13'(cond_flag), 13'h1);
    wr_data(4'b0001);
    check("R7 full after write", 13'(cond_flag), 13'h0);
    cyc();
    check("R7 empty after move", 13'(cond_flag), 13'h1);
    pulse(0);
    wr_data(4'b0010);
    check("R7 queued full", 13'(cond_flag), 13'h0);
    for (int b = 0; b < 7; b++) pulse(0);
    check("R7 still full before hand-over", 13'(cond_flag), 13'h0);
    cyc();
    check("R7 empty after hand-over", 13'(cond_flag), 13'h1);
    pulse(0); pulse(0); pulse(0);
    check("R7 queued nibble bit1", 13'(pins_out[1:0]), 13'b11);
    for (int b = 0; b < 5; b++) pulse(0);

    // R10: disabled ignores data
    wr_ctrl(4'b0000);
    pa2_in = 0;
    wr_data(4'b1111);
    check("R10 R6 cond is pa2", 13'(cond_flag), 13'h0);
    wr_ctrl(4'b1000);
    cyc();
    pulse(0);
    check("R10 nothing sent", 13'(pins_out[0]), 13'h0);
    check("R10 buffer still empty", 13'(cond_flag), 13'h1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule